// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a bank of SDRAM rows from power-on to normal operation. On a start pulse it captures which rows are populated and which CAS latency the mode word should carry. It then lets power and clocks settle, and walks a fixed command list. Each command goes out to every populated row in turn, and each round of commands is followed by a programmed wait.

The command list has four kinds of entry. A no-operation round comes first and a precharge-all round second. Eight auto-refresh rounds follow, and a mode-register-set round comes last. The mode round carries the SDRAM mode word on the address, moved up by three bit positions. Once the wait after the mode round has elapsed, the block returns to the normal command code and asserts refresh enable and done together. Both stay high until the next start pulse. All waits are parameters counted in clock cycles. A start pulse that arrives mid-sequence has no effect.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is held and after its release with no start, cmd_valid, cmd_code, cmd_addr, refresh_enable and done are all zero.
- R2: For the first SETTLE_CYC cycles after the edge that takes a start pulse, no command is issued and refresh_enable and done are low.
- R3: Command rounds come in a fixed order: NOP (code 1), precharge-all (code 2), exactly eight CBR refreshes (code 4), then mode register set (code 3). Codes 5 to 7 are never driven. cmd_code is 0 (normal) whenever cmd_valid is low.
- R4: Each round takes one cycle per row slot, rows 0 to NUM_ROWS-1 in ascending order, with cmd_row giving the slot. cmd_valid is high only in the slots of rows flagged as populated; empty rows are skipped.
- R5: After the last slot of a round the block waits NOP_CYC, PRECHARGE_CYC, REFRESH_CYC or MODE_CYC cycles, matching the kind of round just ended, before the next round starts.
- R6: During mode-set slots cmd_addr carries the mode word shifted left by 3. The word has burst length in bits 2:0 (default 3'b010), burst type in bit 3 (default 1), CAS latency in bits 6:4 (3'b011 when cas3_sel is 1, 3'b010 when it is 0), zeros in bits 8:7, and write-burst mode in bit 9 (default 0). With the defaults this gives 0x1D0 for CAS 3 and 0x150 for CAS 2. cmd_addr is zero at all other times.
- R7: refresh_enable and done rise together in the cycle after the mode wait ends. They stay high until a new start pulse.
- R8: A start pulse while the sequence is running is ignored: the timing and the commands are unchanged.
- R9: The row flags and cas3_sel are captured on the accepted start pulse. Changes to them during the sequence have no effect.
- R10: A start pulse while done is high restarts the sequence. refresh_enable and done drop in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; accepted when idle or done |
| row_pop | input | NUM_ROWS | One flag per row, 1 = populated |
| cas3_sel | input | 1 | 1 selects CAS latency 3, 0 selects CAS latency 2 |
| cmd_valid | output | 1 | A command is issued to cmd_row this cycle |
| cmd_code | output | 3 | Command code: 0 normal, 1 NOP, 2 precharge-all, 3 mode set, 4 CBR refresh |
| cmd_row | output | max(1,clog2(NUM_ROWS)) | Row slot being visited |
| cmd_addr | output | ADDR_W | Mode address during mode-set slots, else zero |
| refresh_enable | output | 1 | Periodic refresh may run |
| done | output | 1 | Initialization complete |

## Verification
Count k cycles from the edge that takes an accepted start. For k from 1 to SETTLE_CYC nothing is issued. Row slot r of round n then falls at k = SETTLE_CYC + 1 + r + n*NUM_ROWS, plus the sum of the waits of the rounds before n. Done and refresh enable appear one cycle after the last mode wait cycle. A bench function maps every k to the expected valid, code, row, address and done values, and the bench compares all outputs at each falling edge against that map. Stray start pulses and input changes are injected at fixed k in the settle window and in a wait gap, and the same map still has to hold.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

   typedef enum logic [2:0] {
      CMD_NORMAL    = 3'd0,
      CMD_NOP       = 3'd1,
      CMD_PRECHARGE = 3'd2,
      CMD_MODE_SET  = 3'd3,
      CMD_CBR       = 3'd4
   } sdr_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_ISSUE,
      ST_GAP,
      ST_READY
   } seq_state_e;

   typedef enum logic [1:0] {
      PH_NOP,
      PH_PRE,
      PH_REF,
      PH_MRS
   } seq_phase_e;

   localparam int REF_ROUNDS = 8;
   localparam int MODE_W     = 10;
   localparam int MODE_SHIFT = 3;

   function automatic sdr_cmd_e phase_code(seq_phase_e p);
      case (p)
         PH_NOP:  return CMD_NOP;
         PH_PRE:  return CMD_PRECHARGE;
         PH_REF:  return CMD_CBR;
         default: return CMD_MODE_SET;
      endcase
   endfunction

   function automatic int max2(int a, int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   if (CNT_W < 1) begin : g_bad_width
      $error("sdr_wait_timer: CNT_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // R5
   tmr_hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && expired) |=> expired);

   // R5
   tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/sdr_row_walker.sv
module sdr_row_walker #(
   parameter int NUM_ROWS = 4,
   localparam int IDX_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear,
   input  logic                step,
   input  logic [NUM_ROWS-1:0] pop,
   output logic [IDX_W-1:0]    idx,
   output logic                hit,
   output logic                last
);

   if (NUM_ROWS < 1) begin : g_bad_rows
      $error("sdr_row_walker: NUM_ROWS must be at least 1");
   end

   if (NUM_ROWS == 1) begin : g_single
      logic unused_walk;
      assign unused_walk = clk ^ rst_n ^ clear ^ step;
      assign idx  = '0;
      assign last = 1'b1;
   end else begin : g_multi
      logic [IDX_W-1:0] idx_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            idx_q <= '0;
         else if (clear)
            idx_q <= '0;
         else if (step && !last)
            idx_q <= idx_q + 1'b1;
      end
      assign idx  = idx_q;
      assign last = (idx_q == IDX_W'(NUM_ROWS - 1));

      // R4
      walk_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         idx_q <= IDX_W'(NUM_ROWS - 1));

      // R4
      walk_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (step && !clear && !last) |=> idx_q == $past(idx_q) + 1'b1);
   end

   assign hit = pop[idx];

endmodule

// File: rtl/sdr_mode_word.sv
module sdr_mode_word #(
   parameter int          ADDR_W     = 13,
   parameter logic [2:0]  BURST_LEN  = 3'b010,
   parameter logic        BURST_TYPE = 1'b1,
   parameter logic        WR_BURST   = 1'b0
) (
   input  logic              cas3_sel,
   output logic [ADDR_W-1:0] mode_addr
);
   import sdr_init_pkg::*;

   localparam int NEED_W = MODE_W + MODE_SHIFT;

   if (ADDR_W < NEED_W) begin : g_bad_addr
      $error("sdr_mode_word: ADDR_W too narrow for shifted mode word");
   end

   logic [MODE_W-1:0] word;
   logic [2:0]        cas_field;

   assign cas_field = cas3_sel ? 3'b011 : 3'b010;
   assign word      = {WR_BURST, 2'b00, cas_field, BURST_TYPE, BURST_LEN};
   assign mode_addr = ADDR_W'(word) << MODE_SHIFT;

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq #(
   parameter int          NUM_ROWS      = 4,
   parameter int          ADDR_W        = 13,
   parameter int          SETTLE_CYC    = 20000,
   parameter int          NOP_CYC       = 200,
   parameter int          PRECHARGE_CYC = 3,
   parameter int          REFRESH_CYC   = 9,
   parameter int          MODE_CYC      = 2,
   parameter logic [2:0]  BURST_LEN     = 3'b010,
   parameter logic        BURST_TYPE    = 1'b1,
   parameter logic        WR_BURST      = 1'b0,
   localparam int         ROW_W         = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [NUM_ROWS-1:0] row_pop,
   input  logic                cas3_sel,
   output logic                cmd_valid,
   output logic [2:0]          cmd_code,
   output logic [ROW_W-1:0]    cmd_row,
   output logic [ADDR_W-1:0]   cmd_addr,
   output logic                refresh_enable,
   output logic                done
);
   import sdr_init_pkg::*;

   localparam int MAX_WAIT = max2(max2(SETTLE_CYC, NOP_CYC),
                                  max2(max2(PRECHARGE_CYC, REFRESH_CYC), MODE_CYC));
   localparam int TMR_W    = $clog2(MAX_WAIT + 1);
   localparam int RCNT_W   = $clog2(REF_ROUNDS);

   if (SETTLE_CYC < 1 || NOP_CYC < 1 || PRECHARGE_CYC < 1 ||
       REFRESH_CYC < 1 || MODE_CYC < 1) begin : g_bad_wait
      $error("sdram_pwrup_seq: every wait must be at least one cycle");
   end

   seq_state_e          state_q;
   seq_phase_e          phase_q;
   logic [RCNT_W-1:0]   ref_cnt_q;
   logic [NUM_ROWS-1:0] pop_q;
   logic                cas3_q;

   logic                accept;
   logic                tmr_load;
   logic [TMR_W-1:0]    tmr_val;
   logic                tmr_done;
   logic                row_hit;
   logic                row_last;
   logic [ROW_W-1:0]    row_idx;
   logic [ADDR_W-1:0]   mode_addr;

   assign accept = start && (state_q == ST_IDLE || state_q == ST_READY);

   function automatic int gap_len(seq_phase_e p);
      case (p)
         PH_NOP:  return NOP_CYC;
         PH_PRE:  return PRECHARGE_CYC;
         PH_REF:  return REFRESH_CYC;
         default: return MODE_CYC;
      endcase
   endfunction

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (accept) begin
         tmr_load = 1'b1;
         tmr_val  = TMR_W'(SETTLE_CYC - 1);
      end else if (state_q == ST_ISSUE && row_last) begin
         tmr_load = 1'b1;
         tmr_val  = TMR_W'(gap_len(phase_q) - 1);
      end
   end

   sdr_wait_timer #(.CNT_W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   sdr_row_walker #(.NUM_ROWS(NUM_ROWS)) u_walker (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state_q != ST_ISSUE),
      .step  (state_q == ST_ISSUE),
      .pop   (pop_q),
      .idx   (row_idx),
      .hit   (row_hit),
      .last  (row_last)
   );

   sdr_mode_word #(
      .ADDR_W     (ADDR_W),
      .BURST_LEN  (BURST_LEN),
      .BURST_TYPE (BURST_TYPE),
      .WR_BURST   (WR_BURST)
   ) u_mode (
      .cas3_sel  (cas3_q),
      .mode_addr (mode_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         phase_q   <= PH_NOP;
         ref_cnt_q <= '0;
         pop_q     <= '0;
         cas3_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE, ST_READY: begin
               if (start) begin
                  state_q   <= ST_SETTLE;
                  phase_q   <= PH_NOP;
                  ref_cnt_q <= '0;
                  pop_q     <= row_pop;
                  cas3_q    <= cas3_sel;
               end
            end
            ST_SETTLE: begin
               if (tmr_done) state_q <= ST_ISSUE;
            end
            ST_ISSUE: begin
               if (row_last) state_q <= ST_GAP;
            end
            ST_GAP: begin
               if (tmr_done) begin
                  state_q <= ST_ISSUE;
                  case (phase_q)
                     PH_NOP: phase_q <= PH_PRE;
                     PH_PRE: phase_q <= PH_REF;
                     PH_REF: begin
                        if (ref_cnt_q == RCNT_W'(REF_ROUNDS - 1))
                           phase_q <= PH_MRS;
                        else
                           ref_cnt_q <= ref_cnt_q + 1'b1;
                     end
                     default: state_q <= ST_READY;
                  endcase
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_valid      = (state_q == ST_ISSUE) && row_hit;
   assign cmd_code       = cmd_valid ? phase_code(phase_q) : CMD_NORMAL;
   assign cmd_row        = row_idx;
   assign cmd_addr       = (cmd_valid && phase_q == PH_MRS) ? mode_addr : '0;
   assign refresh_enable = (state_q == ST_READY);
   assign done           = (state_q == ST_READY);

   // R3
   reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_code <= 3'd4);

   // R3
   normal_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> cmd_code == 3'd0);

   // R6
   addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_code == 3'd3) |-> cmd_addr == '0);

   // R7
   ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && refresh_enable));

   // R7
   refresh_after_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(refresh_enable) |-> ($past(phase_q) == PH_MRS && $past(state_q) == ST_GAP));

   // R8
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (state_q == ST_ISSUE || state_q == ST_GAP)) |=> state_q != ST_SETTLE);

   // R2
   settle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SETTLE) |-> (!cmd_valid && !done));

endmodule

// File: tb/sdram_pwrup_seq_bench.sv
module sdram_pwrup_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NR   = 4;
   localparam int AW   = 13;
   localparam int PWR  = 20;
   localparam int NOPW = 10;
   localparam int TRP  = 3;
   localparam int TRC  = 4;
   localparam int MRSW = 2;
   localparam int TOT  = PWR + 11 * NR + NOPW + TRP + 8 * TRC + MRSW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [NR-1:0] row_pop = '0;
   logic          cas3_sel = 1'b0;
   logic          cmd_valid;
   logic [2:0]    cmd_code;
   logic [1:0]    cmd_row;
   logic [AW-1:0] cmd_addr;
   logic          refresh_enable;
   logic          done;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   logic [NR-1:0] lat_pop;
   logic          lat_cas;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sdram_pwrup_seq #(
      .NUM_ROWS(NR), .ADDR_W(AW), .SETTLE_CYC(PWR), .NOP_CYC(NOPW),
      .PRECHARGE_CYC(TRP), .REFRESH_CYC(TRC), .MODE_CYC(MRSW)
   ) u_sdram_pwrup_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .row_pop(row_pop),
      .cas3_sel(cas3_sel), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_row(cmd_row), .cmd_addr(cmd_addr),
      .refresh_enable(refresh_enable), .done(done)
   );

   function automatic int mode_addr(bit c3);
      logic [9:0] w;
      w = {1'b0, 2'b00, (c3 ? 3'b011 : 3'b010), 1'b1, 3'b010};
      return int'(w) << 3;
   endfunction

   task automatic model(input int k, output bit v, output int code,
                        output int row, output bit rdy, output string tag);
      int pos;
      pos = k - 1; v = 0; code = 0; row = 0; rdy = 0; tag = "R2";
      if (pos < PWR) return;
      pos -= PWR;
      for (int ph = 0; ph < 11; ph++) begin
         int c;
         int w;
         c = (ph == 0) ? 1 : (ph == 1) ? 2 : (ph == 10) ? 3 : 4;
         w = (ph == 0) ? NOPW : (ph == 1) ? TRP : (ph == 10) ? MRSW : TRC;
         if (pos < NR) begin
            row = pos;
            v = lat_pop[pos];
            code = v ? c : 0;
            tag = (v && c == 3) ? "R6" : "R3 R4";
            return;
         end
         pos -= NR;
         if (pos < w) begin
            tag = "R5";
            return;
         end
         pos -= w;
      end
      rdy = 1; tag = "R7";
   endtask

   task automatic check_now(input bit ev, input int ecode, input int erow,
                            input int eaddr, input bit erdy, input string tag);
      bit bad;
      checks++;
      bad = (cmd_valid !== ev) || (int'(cmd_code) != ecode) ||
            (int'(cmd_addr) != eaddr) || (refresh_enable !== erdy) ||
            (done !== erdy) || (ev && int'(cmd_row) != erow);
      if (bad) begin
         fails++;
         $display("FAIL %s t=%0t: got v=%0b code=%0d row=%0d addr=%h ref=%0b done=%0b, expected v=%0b code=%0d row=%0d addr=%h ref/done=%0b",
                  tag, $time, cmd_valid, cmd_code, cmd_row, cmd_addr, refresh_enable,
                  done, ev, ecode, erow, eaddr, erdy);
      end
   endtask

   // One full sequence; noise injects R8 stray starts and R9 input changes.
   task automatic run_seq(input logic [NR-1:0] pop, input bit cas,
                          input bit noise, input bit restart);
      @(negedge clk);
      row_pop = pop; cas3_sel = cas; start = 1'b1;
      lat_pop = pop; lat_cas = cas;
      for (int k = 1; k <= TOT + 3; k++) begin
         bit v; int code; int row; bit rdy; string tag; int ea;
         @(negedge clk);
         model(k, v, code, row, rdy, tag);
         ea = (v && code == 3) ? mode_addr(lat_cas) : 0;
         if (restart && k == 1) tag = "R10";
         if (noise && k > 5) tag = {tag, " R8 R9"};
         check_now(v, code, row, ea, rdy, tag);
         start = noise && (k == 3 || k == PWR + NR + 2);
         if (noise && k == 5) begin
            row_pop = ~pop;
            cas3_sel = ~cas;
         end
      end
   endtask

   initial begin : watchdog
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      fails++;
      checks++;
      $display("FAIL watchdog expired, got %0d cycles, expected fewer", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5D1E_2024));
      repeat (3) @(negedge clk);
      // R1 during reset
      check_now(0, 0, 0, 0, 0, "R1");
      rst_n = 1'b1;
      repeat (4) begin
         @(negedge clk);
         check_now(0, 0, 0, 0, 0, "R1");
      end
      run_seq(4'hF, 1'b1, 1'b0, 1'b0);
      run_seq(4'h0, 1'b0, 1'b0, 1'b1);
      run_seq(4'b1010, 1'b1, 1'b1, 1'b1);
      run_seq(4'b0001, 1'b0, 1'b1, 1'b1);
      for (int i = 0; i < 4; i++) begin
         logic [NR-1:0] p;
         p = NR'($urandom);
         run_seq(p, 1'($urandom), 1'($urandom), 1'b1);
      end
      // R7: done holds with no start
      repeat (10) begin
         @(negedge clk);
         check_now(0, 0, 0, 0, 1, "R7");
      end
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule